// File: doc/BRIEF.md
# Configurable Pipelined Multiplier Slice

This block multiplies an A_W-bit operand by a B_W-bit operand and returns the full (A_W+B_W)-bit product. Each operand goes through an optional input register. A parameter selects what loads that register: the parallel data port, or a cascade input. The cascade input is meant to be fed from the same operand register of an upstream slice. Each operand register drives a cascade output, so a row of slices can form a shift chain of operands.

A per-cycle control bit chooses between two's-complement and unsigned arithmetic. That bit has its own input register, so it stays with the operands it describes. After the multiplier come an optional pipeline register and an optional output register. Each of the three stages (input, pipeline, output) is enabled or bypassed by its own parameter, so the latency is anywhere from zero to three cycles. All registers share one clock enable and one synchronous reset.

Top module: `mul_slice`

## Requirements
- R1: With the signedness control low, the product equals the zero-extended unsigned product of the two operands, A_W+B_W bits wide.
- R2: With the signedness control high, both operands are read as two's complement and the product is the sign-extended signed product, A_W+B_W bits wide (for 9x9, -256 times -256 gives 0x10000).
- R3: Parameter SRC_A / SRC_B set to SRC_SHIFT (1) makes the operand come from the cascade input and ignore the parallel input; SRC_PAR (0) does the reverse.
- R4: The cascade outputs carry the operand register contents, which is the operand loaded at the last enabled edge (the selected source itself when the input stage is bypassed).
- R5: When the clock enable is low and reset is low, no register changes: the product and cascade outputs hold.
- R6: Reset is synchronous and takes priority over the clock enable. It clears every enabled register, including the registered signedness bit, so the product is zero after a reset edge when any stage is enabled.
- R7: Latency from operands to product equals IN_REG+PIPE_REG+OUT_REG enabled-edges, zero meaning purely combinational.
- R8: The signedness control may change on every cycle. When the input stage is enabled it is registered alongside the operands, so each product uses the mode that was sampled with its own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ce | input | 1 | Clock enable for all stages |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | A_W | Parallel operand A |
| b_in | input | B_W | Parallel operand B |
| a_shin | input | A_W | Cascade input for operand A |
| b_shin | input | B_W | Cascade input for operand B |
| sgn_in | input | 1 | 1 = signed operands, 0 = unsigned |
| a_shout | output | A_W | Operand A register contents toward the next slice |
| b_shout | output | B_W | Operand B register contents toward the next slice |
| prod | output | A_W+B_W | Product |

## Verification
A change of signedness can land in the same cycle as a stall or a reset. The bench provokes this by toggling the mode bit every cycle while it randomises the clock enable and fires reset in the middle of a stream. A second slice is chained from the first. Its product therefore mixes operands from one edge earlier with a mode bit from the current edge, and the behavioural history model must predict exactly that mix. Every clock, each product and cascade output is compared with a queue of past operand and mode values, indexed by the latency of that configuration.

// File: rtl/mulsl_pkg.sv
package mulsl_pkg;
  typedef enum logic {
    SRC_PAR   = 1'b0,
    SRC_SHIFT = 1'b1
  } mulsl_src_e;
endpackage

// File: rtl/mulsl_stage.sv
module mulsl_stage #(
  parameter int W  = 8,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         ce,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (EN) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk) begin
        if (rst)     q_r <= '0;
        else if (ce) q_r <= d;
      end
      assign q = q_r;
    end else begin : g_byp
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/mulsl_opnd.sv
module mulsl_opnd
  import mulsl_pkg::*;
#(
  parameter int         W   = 8,
  parameter bit         EN  = 1'b1,
  parameter mulsl_src_e SRC = SRC_PAR
) (
  input  logic         clk,
  input  logic         ce,
  input  logic         rst,
  input  logic [W-1:0] par_d,
  input  logic [W-1:0] sh_d,
  output logic [W-1:0] q
);
  logic [W-1:0] load_val;
  assign load_val = (SRC == SRC_SHIFT) ? sh_d : par_d;

  mulsl_stage #(.W(W), .EN(EN)) u_reg (
    .clk(clk), .ce(ce), .rst(rst), .d(load_val), .q(q)
  );
endmodule

// File: rtl/mulsl_core.sv
module mulsl_core #(
  parameter int A_W = 9,
  parameter int B_W = 9,
  localparam int P_W = A_W + B_W
) (
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  input  logic           sgn,
  output logic [P_W-1:0] p
);
  function automatic logic [P_W-1:0] mul_ext(input logic [A_W-1:0] x,
                                             input logic [B_W-1:0] y,
                                             input logic           s);
    logic [P_W-1:0] xe, ye;
    xe = {{B_W{s & x[A_W-1]}}, x};
    ye = {{A_W{s & y[B_W-1]}}, y};
    return P_W'(xe * ye);
  endfunction

  assign p = mul_ext(a, b, sgn);
endmodule

// File: rtl/mul_slice.sv
module mul_slice
  import mulsl_pkg::*;
#(
  parameter int         A_W      = 9,
  parameter int         B_W      = 9,
  parameter bit         IN_REG   = 1'b1,
  parameter bit         PIPE_REG = 1'b1,
  parameter bit         OUT_REG  = 1'b1,
  parameter mulsl_src_e SRC_A    = SRC_PAR,
  parameter mulsl_src_e SRC_B    = SRC_PAR,
  localparam int        P_W      = A_W + B_W
) (
  input  logic           clk,
  input  logic           ce,
  input  logic           rst,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  input  logic [A_W-1:0] a_shin,
  input  logic [B_W-1:0] b_shin,
  input  logic           sgn_in,
  output logic [A_W-1:0] a_shout,
  output logic [B_W-1:0] b_shout,
  output logic [P_W-1:0] prod
);
  logic [A_W-1:0] a_q;
  logic [B_W-1:0] b_q;
  logic           sgn_q;
  logic [P_W-1:0] mult_p;
  logic [P_W-1:0] pipe_q;

  mulsl_opnd #(.W(A_W), .EN(IN_REG), .SRC(SRC_A)) u_opa (
    .clk(clk), .ce(ce), .rst(rst), .par_d(a_in), .sh_d(a_shin), .q(a_q)
  );

  mulsl_opnd #(.W(B_W), .EN(IN_REG), .SRC(SRC_B)) u_opb (
    .clk(clk), .ce(ce), .rst(rst), .par_d(b_in), .sh_d(b_shin), .q(b_q)
  );

  mulsl_stage #(.W(1), .EN(IN_REG)) u_sgn (
    .clk(clk), .ce(ce), .rst(rst), .d(sgn_in), .q(sgn_q)
  );

  mulsl_core #(.A_W(A_W), .B_W(B_W)) u_mul (
    .a(a_q), .b(b_q), .sgn(sgn_q), .p(mult_p)
  );

  mulsl_stage #(.W(P_W), .EN(PIPE_REG)) u_pipe (
    .clk(clk), .ce(ce), .rst(rst), .d(mult_p), .q(pipe_q)
  );

  mulsl_stage #(.W(P_W), .EN(OUT_REG)) u_out (
    .clk(clk), .ce(ce), .rst(rst), .d(pipe_q), .q(prod)
  );

  assign a_shout = a_q;
  assign b_shout = b_q;
endmodule

// File: rtl/mul_slice_chk.sv
module mul_slice_chk
  import mulsl_pkg::*;
#(
  parameter int         A_W      = 9,
  parameter int         B_W      = 9,
  parameter bit         IN_REG   = 1'b1,
  parameter bit         PIPE_REG = 1'b1,
  parameter bit         OUT_REG  = 1'b1,
  parameter mulsl_src_e SRC_A    = SRC_PAR,
  parameter mulsl_src_e SRC_B    = SRC_PAR,
  localparam int        P_W      = A_W + B_W,
  localparam int        LAT      = int'(IN_REG) + int'(PIPE_REG) + int'(OUT_REG)
) (
  input logic           clk,
  input logic           ce,
  input logic           rst,
  input logic [A_W-1:0] a_in,
  input logic [B_W-1:0] b_in,
  input logic [A_W-1:0] a_shin,
  input logic [B_W-1:0] b_shin,
  input logic           sgn_in,
  input logic [A_W-1:0] a_shout,
  input logic [B_W-1:0] b_shout,
  input logic [P_W-1:0] prod,
  input logic           sgn_q
);
  generate
    if (LAT > 0) begin : g_seq
      // R5: a stall holds the product
      p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(prod));
      // R6: reset clears every stage, product reads zero
      p_rst_zero_r6: assert property (@(posedge clk)
        rst |=> prod == '0);
    end
    if (IN_REG) begin : g_in
      p_sgn_clr_r6: assert property (@(posedge clk)
        rst |=> !sgn_q);
      // R8: mode bit is captured together with operands
      p_sgn_track_r8: assert property (@(posedge clk) disable iff (rst)
        ce |=> sgn_q == $past(sgn_in));
      p_shout_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(a_shout) && $stable(b_shout));
      if (SRC_A == SRC_SHIFT) begin : g_as
        p_shift_a_r3: assert property (@(posedge clk) disable iff (rst)
          ce |=> a_shout == $past(a_shin));
      end else begin : g_ap
        p_par_a_r4: assert property (@(posedge clk) disable iff (rst)
          ce |=> a_shout == $past(a_in));
      end
      if (SRC_B == SRC_SHIFT) begin : g_bs
        p_shift_b_r3: assert property (@(posedge clk) disable iff (rst)
          ce |=> b_shout == $past(b_shin));
      end else begin : g_bp
        p_par_b_r4: assert property (@(posedge clk) disable iff (rst)
          ce |=> b_shout == $past(b_in));
      end
    end else begin : g_noin
      // R7: with no input stage the mode bit passes straight through
      always_comb begin
        if (!rst) p_sgn_pass_r7: assert (sgn_q == sgn_in);
      end
    end
  endgenerate
endmodule

bind mul_slice mul_slice_chk #(
  .A_W(A_W), .B_W(B_W), .IN_REG(IN_REG), .PIPE_REG(PIPE_REG),
  .OUT_REG(OUT_REG), .SRC_A(SRC_A), .SRC_B(SRC_B)
) u_chk (
  .clk(clk), .ce(ce), .rst(rst), .a_in(a_in), .b_in(b_in),
  .a_shin(a_shin), .b_shin(b_shin), .sgn_in(sgn_in),
  .a_shout(a_shout), .b_shout(b_shout), .prod(prod), .sgn_q(sgn_q)
);

// File: tb/test_mul_slice.sv
module test_mul_slice;
  import mulsl_pkg::*;

  logic clk = 1'b0;
  always #2ns clk = ~clk;

  int total = 0;
  int bad   = 0;

  logic       ce_d = 1'b0, rst_d = 1'b1, s_d = 1'b0;
  logic [8:0] a_d = '0, b_d = '0, x_d = '0, j_d = '0;
  logic [5:0] ca = '0;
  logic [3:0] cb = '0;

  logic [8:0]  m_ash, m_bsh, c_ash, c_bsh, p_ash, p_bsh;
  logic [17:0] m_prod, c_prod, p_prod;
  logic [9:0]  k_prod;
  logic [5:0]  k_ash;
  logic [3:0]  k_bsh;

  // latency 3, parallel sources
  mul_slice #(.A_W(9), .B_W(9)) i_mul_slice (
    .clk(clk), .ce(ce_d), .rst(rst_d), .a_in(a_d), .b_in(b_d),
    .a_shin(j_d), .b_shin(j_d), .sgn_in(s_d),
    .a_shout(m_ash), .b_shout(m_bsh), .prod(m_prod));

  // latency 1, both operands from the cascade of the first slice
  mul_slice #(.A_W(9), .B_W(9), .IN_REG(1), .PIPE_REG(0), .OUT_REG(0),
              .SRC_A(SRC_SHIFT), .SRC_B(SRC_SHIFT)) i_mul_slice_chain (
    .clk(clk), .ce(ce_d), .rst(rst_d), .a_in(j_d), .b_in(j_d),
    .a_shin(m_ash), .b_shin(m_bsh), .sgn_in(s_d),
    .a_shout(c_ash), .b_shout(c_bsh), .prod(c_prod));

  // latency 2, no input stage, A from cascade input
  mul_slice #(.A_W(9), .B_W(9), .IN_REG(0), .PIPE_REG(1), .OUT_REG(1),
              .SRC_A(SRC_SHIFT), .SRC_B(SRC_PAR)) i_mul_slice_p2 (
    .clk(clk), .ce(ce_d), .rst(rst_d), .a_in(j_d), .b_in(b_d),
    .a_shin(x_d), .b_shin(j_d), .sgn_in(s_d),
    .a_shout(p_ash), .b_shout(p_bsh), .prod(p_prod));

  // latency 0, 6x4
  mul_slice #(.A_W(6), .B_W(4), .IN_REG(0), .PIPE_REG(0), .OUT_REG(0)) i_mul_slice_comb (
    .clk(clk), .ce(ce_d), .rst(rst_d), .a_in(ca), .b_in(cb),
    .a_shin(6'd0), .b_shin(4'd0), .sgn_in(s_d),
    .a_shout(k_ash), .b_shout(k_bsh), .prod(k_prod));

  // history of operands seen at enabled edges, index 0 = newest
  logic [8:0] ha[4], hb[4], hx[4];
  logic       hs[4];
  initial for (int i = 0; i < 4; i++) begin ha[i] = '0; hb[i] = '0; hx[i] = '0; hs[i] = 1'b0; end

  always @(posedge clk) begin
    if (rst_d) begin
      for (int i = 0; i < 4; i++) begin ha[i] = '0; hb[i] = '0; hx[i] = '0; hs[i] = 1'b0; end
    end else if (ce_d) begin
      for (int i = 3; i > 0; i--) begin
        ha[i] = ha[i-1]; hb[i] = hb[i-1]; hx[i] = hx[i-1]; hs[i] = hs[i-1];
      end
      ha[0] = a_d; hb[0] = b_d; hx[0] = x_d; hs[0] = s_d;
    end
  end

  function automatic longint ref_mul(longint unsigned a, longint unsigned b,
                                     bit s, int aw, int bw);
    longint va = longint'(a);
    longint vb = longint'(b);
    longint r;
    if (s && a[aw-1]) va = va - (longint'(1) <<< aw);
    if (s && b[bw-1]) vb = vb - (longint'(1) <<< bw);
    r = va * vb;
    return r & ((longint'(1) <<< (aw + bw)) - 1);
  endfunction

  task automatic cmp(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    cmp(tag,  "lat3 product", longint'(m_prod), ref_mul(ha[2], hb[2], hs[2], 9, 9));
    cmp(tag,  "lat0 product", longint'(k_prod), ref_mul(ca, cb, s_d, 6, 4));
    cmp("R7", "lat2 product", longint'(p_prod), ref_mul(hx[1], hb[1], hs[1], 9, 9));
    cmp("R3", "chain product", longint'(c_prod), ref_mul(ha[1], hb[1], hs[0], 9, 9));
    cmp("R4", "shout A", longint'(m_ash), longint'(ha[0]));
    cmp("R4", "shout B", longint'(m_bsh), longint'(hb[0]));
    cmp("R4", "chain shout", longint'({c_ash, c_bsh}), longint'({ha[1], hb[1]}));
    cmp("R4", "bypassed shout", longint'(p_ash), longint'(x_d));
  endtask

  task automatic step(string tag, logic ce, logic rst, logic s,
                      logic [8:0] a, logic [8:0] b);
    @(negedge clk);
    ce_d = ce; rst_d = rst; s_d = s; a_d = a; b_d = b;
    x_d = 9'($urandom); j_d = 9'($urandom);
    ca = 6'($urandom); cb = 4'($urandom);
    @(posedge clk);
    #1ns;
    check_all(tag);
  endtask

  bit done = 1'b0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R6: reset state
    step("R6", 1'b1, 1'b1, 1'b1, 9'h1ff, 9'h1ff);
    step("R6", 1'b0, 1'b1, 1'b0, 9'h055, 9'h0aa);
    cmp("R6", "reset product", longint'(m_prod), 0);
    // R1: unsigned stream
    for (int i = 0; i < 60; i++) step("R1", 1'b1, 1'b0, 1'b0, 9'($urandom), 9'($urandom));
    step("R1", 1'b1, 1'b0, 1'b0, 9'h1ff, 9'h1ff);
    repeat (3) step("R1", 1'b1, 1'b0, 1'b0, 9'h000, 9'h000);
    // R2: signed corners
    step("R2", 1'b1, 1'b0, 1'b1, 9'h100, 9'h100);
    step("R2", 1'b1, 1'b0, 1'b1, 9'h1ff, 9'h1ff);
    step("R2", 1'b1, 1'b0, 1'b1, 9'h0ff, 9'h100);
    step("R2", 1'b1, 1'b0, 1'b1, 9'h1ff, 9'h001);
    for (int i = 0; i < 40; i++) step("R2", 1'b1, 1'b0, 1'b1, 9'($urandom), 9'($urandom));
    // R8: mode flips every cycle
    for (int i = 0; i < 80; i++) step("R8", 1'b1, 1'b0, i[0], 9'($urandom), 9'($urandom));
    // R5: random stalls with mode flips
    for (int i = 0; i < 150; i++) step("R5", 1'($urandom), 1'b0, 1'($urandom), 9'($urandom), 9'($urandom));
    // R6: reset mid-stream, with and without enable
    for (int i = 0; i < 100; i++) step("R6", 1'($urandom), ($urandom % 9) == 0, 1'($urandom), 9'($urandom), 9'($urandom));
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule